// File: doc/BRIEF.md
# Committed Register Map with Paired Floating-Point Halves

This block keeps the architectural view of register renaming at the commit point of an out-of-order core. For every logical register it records which physical register holds its committed value. When an instruction commits, its destination mapping is applied to the table. Rename-side allocation and the free list belong to other blocks.

Floating-point logical registers are backed by even/odd physical pairs. A double-precision result maps both halves of a pair at once. A single-precision result writes only one half. The block therefore keeps one half-write record per floating-point pair. When the first half of a pair is written, the whole pair is remapped onto an aligned physical pair and the record notes which half was written. When the other half is then written, the record clears and the mapping is left alone. A committed instruction that reads a floating-point register clears the record of that register's pair. This clearing takes effect before the same instruction's destination is applied.

Logical number 0 means "no register". Numbers 1 to NUM_INT-1 are integer registers. Numbers NUM_INT to NUM_INT+NUM_FP-1 are floating-point registers. A read port returns the committed mapping of any logical register.

Top module: `commit_regmap`

## Requirements
- R1: After reset, every logical register L maps to physical register L, and all pair records are clear.
- R2: When commit is low, the table does not change. A commit whose destination and sources are all 0 also leaves the table unchanged.
- R3: A committed destination in 1..NUM_INT-1 sets its own entry to dstPhys. No other entry changes, whatever the value of isDouble.
- R4: A committed floating-point destination with isDouble high sets the even entry of its pair (dstLog with bit 0 cleared) to dstPhys. It sets the odd entry to dstPhys+1, modulo 2^PHYS_W, and clears the pair record.
- R5: A committed single-precision floating-point destination whose pair record does not hold dstLog^1 does three things. It sets the pair record to dstLog. It sets the even entry to dstPhys with bit 0 cleared. It sets the odd entry to that value plus 1.
- R6: A committed single-precision floating-point destination whose pair record holds dstLog^1 clears the record and leaves the table unchanged. A later single write to the same pair then remaps it as in R5.
- R7: A committed nonzero floating-point source on srcA or srcB clears the record of its pair (logical number shifted right by one). This clearing is applied before the destination rule of the same commit is evaluated.
- R8: rdPhys shows the committed entry for rdLog combinationally, in the same cycle that rdLog is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit | input | 1 | One instruction commits this cycle |
| srcA | input | LOG_W | First logical source, 0 = none |
| srcB | input | LOG_W | Second logical source, 0 = none |
| dstLog | input | LOG_W | Logical destination, 0 = none |
| dstPhys | input | PHYS_W | Physical destination |
| isDouble | input | 1 | Destination is a double-precision result |
| rdLog | input | LOG_W | Logical register to look up |
| rdPhys | output | PHYS_W | Committed physical register for rdLog |

## Verification
The assertions check, on every cycle, that the table does not change when no map write is strobed. They check that a single write lands the strobed value in its entry, that a pair write always leaves the odd entry one above the even entry, and that a completing half write clears its record without touching the table. The bench's scenarios are needed for the rest. Only a sequence of commits can show that a pair is remapped on its first half and left alone on its second. The same holds for the rule that a source in the same commit resets the record first, and for the fact that a cleared record makes the next half write remap again. Those scenarios are checked against a bench model through the read port.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

  // Strobes from the commit decoder to the map storage
  typedef struct packed {
    logic mapWrOne;   // write dst entry with dstPhys
    logic mapWrPair;  // write even/odd entries of dst pair
    logic alignBase;  // clear bit 0 of the pair base first
    logic recSet;     // set pair record to dst
    logic recClr;     // clear pair record of dst
    logic srcAClr;    // clear pair record of srcA
    logic srcBClr;    // clear pair record of srcB
  } cmapStrobes_t;

endpackage

// File: rtl/cmap_ctrl.sv
module cmap_ctrl
  import cmap_pkg::*;
#(
  parameter int NUM_INT = 32,
  parameter int NUM_FP  = 32,
  parameter int LOG_W   = 6
) (
  input  logic             commit,
  input  logic [LOG_W-1:0] srcA,
  input  logic [LOG_W-1:0] srcB,
  input  logic [LOG_W-1:0] dstLog,
  input  logic             isDouble,
  input  logic [LOG_W-1:0] recAtDst,
  output cmapStrobes_t     strb
);
  localparam int FP_LO = NUM_INT;
  localparam int FP_HI = NUM_INT + NUM_FP;

  function automatic logic isFp(input logic [LOG_W-1:0] l);
    return ({1'b0, l} >= (LOG_W+1)'(FP_LO)) && ({1'b0, l} < (LOG_W+1)'(FP_HI));
  endfunction

  function automatic logic samePair(input logic [LOG_W-1:0] a, input logic [LOG_W-1:0] b);
    return a[LOG_W-1:1] == b[LOG_W-1:1];
  endfunction

  logic srcAValid, srcBValid, dstValid, dstIsFp, srcHitsDst;
  logic [LOG_W-1:0] effRec;

  assign srcAValid  = commit && (srcA != '0) && isFp(srcA);
  assign srcBValid  = commit && (srcB != '0) && isFp(srcB);
  assign dstValid   = commit && (dstLog != '0);
  assign dstIsFp    = isFp(dstLog);
  // sources clear their records before the destination rule looks at them
  assign srcHitsDst = (srcAValid && samePair(srcA, dstLog)) ||
                      (srcBValid && samePair(srcB, dstLog));
  assign effRec     = srcHitsDst ? '0 : recAtDst;

  always_comb begin
    strb         = '0;
    strb.srcAClr = srcAValid;
    strb.srcBClr = srcBValid;
    if (dstValid) begin
      if (!dstIsFp) begin
        strb.mapWrOne = 1'b1;
      end else if (isDouble) begin
        strb.mapWrPair = 1'b1;
        strb.recClr    = 1'b1;
      end else if (effRec == (dstLog ^ LOG_W'(1))) begin
        strb.recClr = 1'b1;
      end else begin
        strb.mapWrPair = 1'b1;
        strb.alignBase = 1'b1;
        strb.recSet    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmap_store.sv
module cmap_store
  import cmap_pkg::*;
#(
  parameter int NUM_INT = 32,
  parameter int NUM_FP  = 32,
  parameter int LOG_W   = 6,
  parameter int PHYS_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  cmapStrobes_t      strb,
  input  logic [LOG_W-1:0]  srcA,
  input  logic [LOG_W-1:0]  srcB,
  input  logic [LOG_W-1:0]  dstLog,
  input  logic [PHYS_W-1:0] dstPhys,
  input  logic [LOG_W-1:0]  rdLog,
  output logic [PHYS_W-1:0] rdPhys,
  output logic [LOG_W-1:0]  recAtDst
);
  localparam int NUM_LOG   = NUM_INT + NUM_FP;
  localparam int NUM_PAIRS = NUM_FP / 2;
  localparam int PAIR_W    = $clog2(NUM_PAIRS);
  localparam int PAIR_OFS  = NUM_INT / 2;

  logic [PHYS_W-1:0] mapTab [NUM_LOG];
  logic [LOG_W-1:0]  rec    [NUM_PAIRS];
  logic [NUM_LOG*PHYS_W-1:0] mapFlat;

  function automatic logic [PAIR_W-1:0] pairOf(input logic [LOG_W-1:0] l);
    logic [LOG_W-2:0] p;
    p = l[LOG_W-1:1] - (LOG_W-1)'(PAIR_OFS);
    return p[PAIR_W-1:0];
  endfunction

  logic [LOG_W-1:0]  dstEven, dstOdd;
  logic [PHYS_W-1:0] pairBase;
  logic [PAIR_W-1:0] dstPair, srcAPair, srcBPair;

  assign dstEven  = {dstLog[LOG_W-1:1], 1'b0};
  assign dstOdd   = {dstLog[LOG_W-1:1], 1'b1};
  assign pairBase = strb.alignBase ? {dstPhys[PHYS_W-1:1], 1'b0} : dstPhys;
  assign dstPair  = pairOf(dstLog);
  assign srcAPair = pairOf(srcA);
  assign srcBPair = pairOf(srcB);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LOG; i++) mapTab[i] <= PHYS_W'(i);
    end else begin
      if (strb.mapWrOne) mapTab[dstLog] <= dstPhys;
      if (strb.mapWrPair) begin
        mapTab[dstEven] <= pairBase;
        mapTab[dstOdd]  <= pairBase + PHYS_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PAIRS; p++) rec[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if ((strb.srcAClr && srcAPair == PAIR_W'(p)) ||
            (strb.srcBClr && srcBPair == PAIR_W'(p)))
          rec[p] <= '0;
        if (dstPair == PAIR_W'(p)) begin
          if (strb.recClr)      rec[p] <= '0;
          else if (strb.recSet) rec[p] <= dstLog;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_LOG; g++) begin : g_flat
    assign mapFlat[g*PHYS_W +: PHYS_W] = mapTab[g];
  end

  assign rdPhys   = mapTab[rdLog];
  assign recAtDst = rec[dstPair];

  AST_TABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!strb.mapWrOne && !strb.mapWrPair) |=> $stable(mapFlat)); // R2

  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    strb.mapWrOne |=> (mapTab[$past(dstLog)] == $past(dstPhys))); // R3

  AST_PAIR_CONSECUTIVE: assert property (@(posedge clk) disable iff (rst)
    strb.mapWrPair |=> (mapTab[$past(dstOdd)] == mapTab[$past(dstEven)] + PHYS_W'(1))); // R4

  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    strb.recSet |=> (rec[$past(dstPair)] == $past(dstLog)) &&
                    (mapTab[$past(dstEven)][0] == 1'b0)); // R5

  AST_COMPLETE_NO_REMAP: assert property (@(posedge clk) disable iff (rst)
    (strb.recClr && !strb.mapWrPair) |=> (rec[$past(dstPair)] == '0) && $stable(mapFlat)); // R6

endmodule

// File: rtl/commit_regmap.sv
module commit_regmap
  import cmap_pkg::*;
#(
  parameter int NUM_INT = 32,
  parameter int NUM_FP  = 32,
  parameter int PHYS_W  = 7,
  localparam int LOG_W  = $clog2(NUM_INT + NUM_FP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [LOG_W-1:0]  srcA,
  input  logic [LOG_W-1:0]  srcB,
  input  logic [LOG_W-1:0]  dstLog,
  input  logic [PHYS_W-1:0] dstPhys,
  input  logic              isDouble,
  input  logic [LOG_W-1:0]  rdLog,
  output logic [PHYS_W-1:0] rdPhys
);
  cmapStrobes_t     strb;
  logic [LOG_W-1:0] recAtDst;

  cmap_ctrl #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .LOG_W(LOG_W)) i_ctrl (
    .commit(commit), .srcA(srcA), .srcB(srcB), .dstLog(dstLog),
    .isDouble(isDouble), .recAtDst(recAtDst), .strb(strb)
  );

  cmap_store #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .LOG_W(LOG_W), .PHYS_W(PHYS_W)) i_store (
    .clk(clk), .rst(rst), .strb(strb), .srcA(srcA), .srcB(srcB),
    .dstLog(dstLog), .dstPhys(dstPhys), .rdLog(rdLog), .rdPhys(rdPhys),
    .recAtDst(recAtDst)
  );

endmodule

// File: tb/test_commit_regmap.sv
module test_commit_regmap;
  localparam int CLK_PERIOD = 10;
  localparam int NLOG = 64;
  localparam int PMOD = 128;

  logic clk = 1'b0;
  logic rst, commit, isDouble;
  logic [5:0] srcA, srcB, dstLog, rdLog;
  logic [6:0] dstPhys, rdPhys;

  int checks = 0;
  int fails  = 0;
  int refMap [NLOG];
  int refRec [NLOG/2];

  always #(CLK_PERIOD/2) clk = ~clk;

  commit_regmap i_commit_regmap (
    .clk(clk), .rst(rst), .commit(commit), .srcA(srcA), .srcB(srcB),
    .dstLog(dstLog), .dstPhys(dstPhys), .isDouble(isDouble),
    .rdLog(rdLog), .rdPhys(rdPhys)
  );

  function automatic void modelReset();
    for (int i = 0; i < NLOG; i++) refMap[i] = i;
    for (int i = 0; i < NLOG/2; i++) refRec[i] = 0;
  endfunction

  function automatic void modelCommit(int s0, int s1, int d, int p, bit dbl);
    if (s0 >= 32) refRec[s0 >> 1] = 0;
    if (s1 >= 32) refRec[s1 >> 1] = 0;
    if (d > 0) begin
      if (d < 32) refMap[d] = p;
      else if (dbl) begin
        refMap[d & ~1] = p;
        refMap[d | 1]  = (p + 1) % PMOD;
        refRec[d >> 1] = 0;
      end else if (refRec[d >> 1] == (d ^ 1)) begin
        refRec[d >> 1] = 0;
      end else begin
        refRec[d >> 1] = d;
        refMap[d & ~1] = p & ~1;
        refMap[d | 1]  = (p & ~1) + 1;
      end
    end
  endfunction

  task automatic checkEntry(int idx, string tag);
    rdLog = 6'(idx);
    #1;
    checks++;
    if (int'(rdPhys) != refMap[idx]) begin
      fails++;
      $display("FAIL %s: entry %0d actual %0d expected %0d", tag, idx, rdPhys, refMap[idx]);
    end
  endtask

  task automatic checkAll(string tag);
    for (int i = 0; i < NLOG; i++) checkEntry(i, tag);
  endtask

  task automatic doCommit(int s0, int s1, int d, int p, bit dbl);
    @(negedge clk);
    srcA = 6'(s0); srcB = 6'(s1); dstLog = 6'(d); dstPhys = 7'(p); isDouble = dbl;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    modelCommit(s0, s1, d, p, dbl);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int s0, s1, d, p;
    bit dbl;
    void'($urandom(32'd2024));
    rst = 1'b1; commit = 1'b0; isDouble = 1'b0;
    srcA = '0; srcB = '0; dstLog = '0; dstPhys = '0; rdLog = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelReset();
    checkAll("R1");

    // R2: inputs present but commit low; then an all-zero commit
    @(negedge clk);
    srcA = 6'd33; dstLog = 6'd5; dstPhys = 7'd99; isDouble = 1'b0;
    repeat (2) @(negedge clk);
    checkAll("R2");
    doCommit(0, 0, 0, 77, 0);
    checkAll("R2");

    // R3: integer destination, also with the double flag set
    doCommit(0, 0, 5, 100, 0);
    checkEntry(5, "R3"); checkEntry(4, "R3"); checkEntry(6, "R3");
    doCommit(0, 0, 7, 33, 1);
    checkEntry(7, "R3"); checkEntry(6, "R3"); checkEntry(8, "R3");

    // R4: double destination, including odd logical number and wrap
    doCommit(0, 0, 40, 70, 1);
    checkEntry(40, "R4"); checkEntry(41, "R4");
    doCommit(0, 0, 51, 127, 1);
    checkEntry(50, "R4"); checkEntry(51, "R4");

    // R5: first half written remaps pair, aligned
    doCommit(0, 0, 43, 91, 0);
    checkEntry(42, "R5"); checkEntry(43, "R5");

    // R6: other half completes without remap; next write remaps again
    doCommit(0, 0, 42, 55, 0);
    checkEntry(42, "R6"); checkEntry(43, "R6");
    doCommit(0, 0, 42, 55, 0);
    checkEntry(42, "R6"); checkEntry(43, "R6");

    // R7: a source clears the record in an earlier commit
    doCommit(0, 0, 44, 20, 0);
    doCommit(45, 0, 0, 0, 0);
    doCommit(0, 0, 45, 30, 0);
    checkEntry(44, "R7"); checkEntry(45, "R7");
    // R7: source in the same commit is applied before the destination
    doCommit(0, 0, 46, 10, 0);
    doCommit(0, 47, 47, 12, 0);
    checkEntry(46, "R7"); checkEntry(47, "R7");

    // mixed random commits
    for (int n = 0; n < 400; n++) begin
      d   = ($urandom % 4 == 0) ? 1 + $urandom % 31 : 32 + $urandom % 32;
      if ($urandom % 10 == 0) d = 0;
      s0  = ($urandom % 2 == 0) ? 0 : $urandom % 64;
      s1  = ($urandom % 3 == 0) ? $urandom % 64 : 0;
      p   = $urandom % PMOD;
      dbl = ($urandom % 3 == 0);
      doCommit(s0, s1, d, p, dbl);
      checkEntry(d, "mix");
      checkEntry(d ^ 1, "mix");
      checkEntry($urandom % 64, "mix");
    end

    checkAll("R8");
    finishRun();
  end

endmodule